// File: doc/BRIEF.md
# Boot Download Retry Sequencer

This block runs the download of a fixed-length boot image into a loader. A boot request starts a preload phase: the block pulses a kick output and waits for the preload to report completion. It then offers the image one word at a time on a valid/ready channel. The word index is presented on an address output, and the image word read from outside storage passes straight through to the data output. When the last word has been accepted, the block pulses a launch command. It then waits for the loader to report that the launch succeeded or failed.

During the preload or the streaming phase, the loader may raise a transfer error that carries a 2-bit reason. The block then counts the failure under that reason and records how many words the failed attempt had moved. It restarts the whole download from the preload kick. After a set number of transfer failures it abandons the boot. A launch failure ends the boot at once and is never retried. The diagnostics are visible on a 32-bit status word, next to a done flag and a failed flag.

Top module: `boot_xfer_seq`

## Requirements
- R1: After reset, done, failed, kick, word valid and launch are all low and the status word is zero.
- R2: A boot request clears the whole status word, which reads zero in the following cycle, and pulses kick for exactly one cycle in that same following cycle. Streaming starts only after preload_done is seen in a later cycle.
- R3: While streaming, word valid is high and the address output shows the index of the next word, from 0 to IMG_WORDS-1. The index moves on only in a cycle where both valid and ready are high.
- R4: A transfer error taken in the preload or streaming phase adds one to the 4-bit counter of its reason code k. That counter sits at status bits [4k+3:4k].
- R5: On a transfer error, status bits [31:16] take the number of words accepted in the failed attempt before the error.
- R6: After a transfer error that is not the last allowed one, kick pulses again in the next cycle and streaming restarts at index 0. Failure counters persist across these retries.
- R7: When transfer failures reach MAX_FAILS (10 by default), failed goes high and launch is never issued.
- R8: One cycle after the last word is accepted, launch is high for exactly one cycle. A launch success then raises done.
- R9: A launch failure raises failed in the next cycle. No further kick or launch follows.
- R10: Done and failed are never high together, and each holds until the next boot request. A transfer error raised while idle, launching, done or failed changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_req | input | 1 | Start a new boot; clears diagnostics |
| kick | output | 1 | One-cycle request to begin the preload phase |
| preload_done | input | 1 | Preload phase finished |
| wd_valid | output | 1 | Word offered to the loader |
| wd_ready | input | 1 | Loader accepts the offered word |
| wd_addr | output | $clog2(IMG_WORDS) | Index of the offered word |
| img_rdata | input | DATA_W | Image word at wd_addr from outside storage |
| wd_data | output | DATA_W | Offered word |
| xfer_err | input | 1 | Transfer failure report |
| xfer_code | input | 2 | Reason of the transfer failure |
| launch | output | 1 | One-cycle start command after a full transfer |
| launch_ok | input | 1 | Start command succeeded |
| launch_fail | input | 1 | Start command failed |
| status | output | 32 | [31:16] words before last failure, [15:0] four reason counters |
| done | output | 1 | Boot completed |
| failed | output | 1 | Boot abandoned |

## Verification
The hardest state to reach is the give-up boundary. Reaching it takes ten complete restart cycles, each with its own kick and preload handshake, with the failure injected at a chosen word. The bench drives this as a loop of preload-and-stream attempts. One scenario stops at nine failures and then succeeds, and another reaches the tenth. A rotating reason code spreads the failures over all four counters.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_KICK   = 3'd1,
        ST_PRE    = 3'd2,
        ST_STREAM = 3'd3,
        ST_LAUNCH = 3'd4,
        ST_WAIT   = 3'd5,
        ST_DONE   = 3'd6,
        ST_FAIL   = 3'd7
    } seq_state_t;

    localparam int unsigned NUM_CODES = 4;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned FIELD_W   = 16;

endpackage

// File: rtl/boot_word_pump.sv
module boot_word_pump #(
    parameter int unsigned IMG_WORDS = 8,
    parameter int unsigned FIELD_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         adv,
    output logic [$clog2(IMG_WORDS)-1:0] addr,
    output logic                         last,
    output logic [FIELD_W-1:0]           count
);
    localparam int unsigned AW = $clog2(IMG_WORDS);
    localparam int unsigned CW = $clog2(IMG_WORDS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pump_t;

    pump_t cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (clr) begin
            cur_d.cnt = '0;
        end else if (adv) begin
            cur_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign addr  = cur_q.cnt[AW-1:0];
    assign last  = (cur_q.cnt == CW'(IMG_WORDS - 1));
    assign count = FIELD_W'(cur_q.cnt);

endmodule

// File: rtl/boot_fail_log.sv
module boot_fail_log #(
    parameter int unsigned MAX_FAILS = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr_all,
    input  logic                                 fail_ev,
    input  logic [1:0]                           code,
    input  logic [boot_seq_pkg::FIELD_W-1:0]     words,
    output logic [boot_seq_pkg::FIELD_W-1:0]     nib_field,
    output logic [boot_seq_pkg::FIELD_W-1:0]     word_field,
    output logic                                 last_allowed
);
    import boot_seq_pkg::*;

    localparam int unsigned TW = $clog2(MAX_FAILS + 1);

    typedef struct packed {
        logic [NUM_CODES-1:0][NIB_W-1:0] nib;
        logic [FIELD_W-1:0]              wat;
        logic [TW-1:0]                   total;
    } log_t;

    log_t log_q, log_d;

    always_comb begin
        log_d = log_q;
        if (clr_all) begin
            log_d = '0;
        end else if (fail_ev) begin
            log_d.wat   = words;
            log_d.total = log_q.total + TW'(1);
            for (int k = 0; k < NUM_CODES; k++) begin
                if (code == 2'(k) && log_q.nib[k] != {NIB_W{1'b1}}) begin
                    log_d.nib[k] = log_q.nib[k] + NIB_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign nib_field    = log_q.nib;
    assign word_field   = log_q.wat;
    assign last_allowed = (log_q.total == TW'(MAX_FAILS - 1));

endmodule

// File: rtl/boot_xfer_seq.sv
module boot_xfer_seq #(
    parameter int unsigned IMG_WORDS = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned MAX_FAILS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         boot_req,
    output logic                         kick,
    input  logic                         preload_done,
    output logic                         wd_valid,
    input  logic                         wd_ready,
    output logic [$clog2(IMG_WORDS)-1:0] wd_addr,
    input  logic [DATA_W-1:0]            img_rdata,
    output logic [DATA_W-1:0]            wd_data,
    input  logic                         xfer_err,
    input  logic [1:0]                   xfer_code,
    output logic                         launch,
    input  logic                         launch_ok,
    input  logic                         launch_fail,
    output logic [31:0]                  status,
    output logic                         done,
    output logic                         failed
);
    import boot_seq_pkg::*;

    typedef struct packed {
        seq_state_t st;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic               pump_clr, pump_adv, pump_last;
    logic               log_clr, fail_ev, give_up;
    logic [FIELD_W-1:0] word_count, nib_field, word_field;
    logic               err_window;

    assign err_window = (ctl_q.st == ST_PRE) || (ctl_q.st == ST_STREAM);

    always_comb begin
        ctl_d    = ctl_q;
        log_clr  = 1'b0;
        fail_ev  = 1'b0;
        pump_adv = 1'b0;
        if (boot_req) begin
            log_clr  = 1'b1;
            ctl_d.st = ST_KICK;
        end else begin
            fail_ev = err_window && xfer_err;
            case (ctl_q.st)
                ST_KICK:   ctl_d.st = ST_PRE;
                ST_PRE: begin
                    if (preload_done) ctl_d.st = ST_STREAM;
                end
                ST_STREAM: begin
                    pump_adv = wd_ready && !xfer_err;
                    if (pump_adv && pump_last) ctl_d.st = ST_LAUNCH;
                end
                ST_LAUNCH: ctl_d.st = ST_WAIT;
                ST_WAIT: begin
                    if (launch_fail)    ctl_d.st = ST_FAIL;
                    else if (launch_ok) ctl_d.st = ST_DONE;
                end
                default: ctl_d.st = ctl_q.st;
            endcase
            if (fail_ev) begin
                ctl_d.st = give_up ? ST_FAIL : ST_KICK;
            end
        end
        pump_clr = (ctl_d.st == ST_KICK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    boot_word_pump #(
        .IMG_WORDS (IMG_WORDS),
        .FIELD_W   (FIELD_W)
    ) u_pump (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pump_clr),
        .adv   (pump_adv),
        .addr  (wd_addr),
        .last  (pump_last),
        .count (word_count)
    );

    boot_fail_log #(
        .MAX_FAILS (MAX_FAILS)
    ) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_all      (log_clr),
        .fail_ev      (fail_ev),
        .code         (xfer_code),
        .words        (word_count),
        .nib_field    (nib_field),
        .word_field   (word_field),
        .last_allowed (give_up)
    );

    assign kick     = (ctl_q.st == ST_KICK);
    assign wd_valid = (ctl_q.st == ST_STREAM);
    assign wd_data  = img_rdata;
    assign launch   = (ctl_q.st == ST_LAUNCH);
    assign done     = (ctl_q.st == ST_DONE);
    assign failed   = (ctl_q.st == ST_FAIL);
    assign status   = {word_field, nib_field};

endmodule

// File: rtl/boot_xfer_seq_chk.sv
module boot_xfer_seq_chk #(
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boot_req,
    input logic          kick,
    input logic          wd_valid,
    input logic          wd_ready,
    input logic [AW-1:0] wd_addr,
    input logic          xfer_err,
    input logic          launch,
    input logic [31:0]   status,
    input logic          done,
    input logic          failed
);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && failed));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !boot_req) |=> done);

    assert_fail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (failed && !boot_req) |=> failed);

    assert_kick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !boot_req) |=> !kick);

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |=> (status == 32'h0 && kick));

    assert_launch_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !boot_req) |=> !launch);

    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready && !xfer_err && !boot_req) |=> (wd_valid && $stable(wd_addr)));

    assert_no_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> !launch);

endmodule

bind boot_xfer_seq boot_xfer_seq_chk #(
    .AW ($clog2(IMG_WORDS))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_req (boot_req),
    .kick     (kick),
    .wd_valid (wd_valid),
    .wd_ready (wd_ready),
    .wd_addr  (wd_addr),
    .xfer_err (xfer_err),
    .launch   (launch),
    .status   (status),
    .done     (done),
    .failed   (failed)
);

// File: tb/boot_xfer_seq_bench.sv
module boot_xfer_seq_bench;
    localparam int IMG = 8;
    localparam int AW  = $clog2(IMG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_req = 1'b0, preload_done = 1'b0, wd_ready = 1'b0;
    logic xfer_err = 1'b0, launch_ok = 1'b0, launch_fail = 1'b0;
    logic [1:0] xfer_code = 2'd0;
    logic [15:0] img_rdata;
    logic kick, wd_valid, launch, done, failed;
    logic [AW-1:0] wd_addr;
    logic [15:0] wd_data;
    logic [31:0] status;

    int n_chk = 0, n_bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    assign img_rdata = 16'hA500 | 16'(wd_addr);

    boot_xfer_seq u_boot_xfer_seq (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .kick(kick),
        .preload_done(preload_done), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_addr(wd_addr), .img_rdata(img_rdata), .wd_data(wd_data),
        .xfer_err(xfer_err), .xfer_code(xfer_code), .launch(launch),
        .launch_ok(launch_ok), .launch_fail(launch_fail), .status(status),
        .done(done), .failed(failed)
    );

    typedef struct packed {
        logic [3:0] nfail;
        logic [1:0] code;
        logic       rot;
        logic [3:0] fail_at;
        logic       stall;
        logic       sok;
    } scen_t;

    localparam scen_t TAB [7] = '{
        '{4'd0,  2'd0, 1'b0, 4'd0, 1'b0, 1'b1},
        '{4'd1,  2'd2, 1'b0, 4'd3, 1'b0, 1'b1},
        '{4'd3,  2'd1, 1'b0, 4'd0, 1'b1, 1'b1},
        '{4'd0,  2'd0, 1'b0, 4'd0, 1'b1, 1'b0},
        '{4'd10, 2'd3, 1'b0, 4'd5, 1'b0, 1'b1},
        '{4'd9,  2'd0, 1'b0, 4'd7, 1'b1, 1'b1},
        '{4'd6,  2'd0, 1'b1, 4'd2, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic request();
        @(negedge clk);
        boot_req = 1'b1;
        @(negedge clk);
        boot_req = 1'b0;
        chk(status == 32'h0, "R2 status cleared", status, 32'h0);
    endtask

    // one attempt: kick, preload, stream; fail_at < IMG injects an error there
    task automatic attempt(input int fail_at, input logic [1:0] code, input bit stall);
        int acc = 0;
        int cyc = 0;
        bit prev = 1'b0;
        bit addr_ok = 1'b1;
        for (int w = 0; w < 50 && !kick; w++) @(negedge clk);
        chk(kick == 1'b1, "R6 kick at attempt start", 32'(kick), 32'h1);
        @(negedge clk);
        chk(wd_valid == 1'b0, "R2 no stream before preload_done", 32'(wd_valid), 32'h0);
        preload_done = 1'b1;
        @(negedge clk);
        preload_done = 1'b0;
        forever begin
            if (prev) acc++;
            if (acc == IMG) break;
            if (!wd_valid || wd_addr != AW'(acc) || wd_data != (16'hA500 | 16'(acc))) addr_ok = 1'b0;
            if (acc == fail_at) begin
                wd_ready  = 1'b0;
                xfer_err  = 1'b1;
                xfer_code = code;
                @(negedge clk);
                xfer_err = 1'b0;
                break;
            end
            wd_ready = stall ? cyc[0] : 1'b1;
            prev = wd_ready && wd_valid;
            cyc++;
            @(negedge clk);
        end
        wd_ready = 1'b0;
        chk(addr_ok, "R3 word order and data", 32'(acc), 32'(fail_at));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles == 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({done, failed, kick, wd_valid, launch} == 5'b0, "R1 idle outputs", 32'({done, failed, kick, wd_valid, launch}), 32'h0);
        chk(status == 32'h0, "R1 status zero", status, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 32'h0 && !kick, "R1 after release", status, 32'h0);

        for (int s = 0; s < 7; s++) begin
            int nib [4] = '{0, 0, 0, 0};
            int nf = int'(TAB[s].nfail);
            bit gave = (nf >= 10);
            logic [31:0] exp_st;
            request();
            for (int i = 0; i < nf; i++) begin
                logic [1:0] c = TAB[s].rot ? 2'(int'(TAB[s].code) + i) : TAB[s].code;
                nib[c]++;
                attempt(int'(TAB[s].fail_at), c, TAB[s].stall);
            end
            exp_st = {(nf > 0) ? 16'(TAB[s].fail_at) : 16'h0,
                      4'(nib[3]), 4'(nib[2]), 4'(nib[1]), 4'(nib[0])};
            if (gave) begin
                chk(failed && !done, "R7 give up at limit", 32'({done, failed}), 32'h1);
                chk(status == exp_st, "R4 R5 counters at give up", status, exp_st);
                for (int w = 0; w < 10; w++) begin
                    @(negedge clk);
                    chk(!launch && !kick, "R7 no launch after give up", 32'({launch, kick}), 32'h0);
                end
                chk(failed, "R10 failed held", 32'(failed), 32'h1);
            end else begin
                attempt(IMG, 2'd0, TAB[s].stall);
                chk(launch == 1'b1, "R8 launch after last word", 32'(launch), 32'h1);
                @(negedge clk);
                chk(launch == 1'b0, "R8 launch one cycle", 32'(launch), 32'h0);
                if (TAB[s].sok) launch_ok = 1'b1; else launch_fail = 1'b1;
                @(negedge clk);
                launch_ok = 1'b0;
                launch_fail = 1'b0;
                if (TAB[s].sok) begin
                    chk(done && !failed, "R8 done after launch ok", 32'({done, failed}), 32'h2);
                end else begin
                    chk(failed && !done, "R9 failed after launch fail", 32'({done, failed}), 32'h1);
                    for (int w = 0; w < 12; w++) begin
                        @(negedge clk);
                        chk(!kick && !launch, "R9 no retry", 32'({kick, launch}), 32'h0);
                    end
                end
                chk(status == exp_st, "R4 R5 status word", status, exp_st);
            end
        end

        // error raised during the preload phase
        request();
        @(negedge clk);
        xfer_err  = 1'b1;
        xfer_code = 2'd1;
        @(negedge clk);
        xfer_err = 1'b0;
        chk(status == 32'h0000_0010, "R4 preload-phase error", status, 32'h0000_0010);
        chk(kick == 1'b1, "R6 restart after preload error", 32'(kick), 32'h1);
        attempt(IMG, 2'd0, 1'b0);
        @(negedge clk);
        launch_ok = 1'b1;
        @(negedge clk);
        launch_ok = 1'b0;
        chk(done, "R8 done after preload retry", 32'(done), 32'h1);

        // error outside the transfer window is ignored
        xfer_err  = 1'b1;
        xfer_code = 2'd3;
        @(negedge clk);
        xfer_err = 1'b0;
        @(negedge clk);
        chk(status == 32'h0000_0010 && done && !kick, "R10 late error ignored", status, 32'h0000_0010);

        // a new request clears and restarts from done
        request();
        chk(!done && kick, "R10 done cleared by request", 32'({done, kick}), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule